// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Burst, Lock and Split Tracking

This block decides which of up to sixteen masters drives the address phase of a pipelined system bus. Each master raises its own request line, and may also raise a lock line. The arbiter samples these at every rising clock edge, picks the lowest-numbered eligible requester, and presents a one-hot grant. A master becomes the owner only at an edge where its grant and the bus ready signal are both high. At that edge the 4-bit owner number updates, and so does a flag that marks a locked sequence.

The arbiter watches the transfer type and burst type that the owner drives. For a fixed-length burst it counts completed beats and keeps the grant with the owner until the burst ends, even if the owner drops its request. The grant moves at the edge that samples the penultimate address, so the next master sees its grant together with the last address. A burst of undefined length keeps the grant only while the owner keeps requesting. A locked sequence keeps the grant while the owner holds its lock line. A master that receives a split response is masked out until a slave names it on the split-release input. When no master is eligible, the bus parks on a default master.

Top module: `bus_arbiter`

## Requirements
- R1: After a synchronous reset the grant selects the default master (parameter DEFAULT_M, 0 by default), the owner number equals DEFAULT_M and the locked flag is low. Exactly one grant bit is high in every cycle.
- R2: At each rising edge with no hold active, the next grant goes to the lowest-indexed master whose request is high and which is not split-masked. The new grant is visible after that edge.
- R3: The owner number takes the index of the granted master at an edge where ready is high, and keeps its value at edges where ready is low.
- R4: Burst type encodings are 000 single, 001 undefined-length incrementing, 010/011 four beats, 100/101 eight beats, 110/111 sixteen beats. Transfer encodings are 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ. A beat counts only when it is NONSEQ or SEQ and ready is high. BUSY beats and wait cycles do not count. An IDLE beat with ready high ends any burst. While two or more beats of a fixed burst remain, the grant stays with the owner whatever the requests are.
- R5: The grant leaves a fixed-length burst's owner at the edge that samples the penultimate beat. For a single transfer this is the edge that samples that transfer. Ownership passes at the next edge with ready high.
- R6: After a NONSEQ beat with burst type 001, the grant stays with the owner while the owner's request is high. It is rearbitrated at the first edge where that request is low.
- R7: At each edge with ready high, the locked flag takes the lock line of the master that is granted before that edge. While the flag is high and the owner holds its lock line, the grant stays with the owner.
- R8: A split response (split-response input high together with ready) masks the master that owns the data phase. A master is in the data phase after an edge with ready high at which it was the owner. The mask takes effect in the arbitration at that same edge. A mask bit clears at the edge where the matching split-release bit is high, and that master can be granted at the same edge. A split response also ends any burst or hold.
- R9: When no master is eligible and no hold is active, the grant goes to DEFAULT_M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Per-master bus request |
| lock_i | input | 16 | Per-master lock request |
| trans_i | input | 2 | Transfer type driven by the current owner |
| burst_i | input | 3 | Burst type driven by the current owner |
| ready_i | input | 1 | Bus ready; a transfer completes when high |
| split_resp_i | input | 1 | Slave gives a split response to the data-phase master |
| split_done_i | input | 16 | Split release, one bit per master |
| grant_o | output | 16 | One-hot grant |
| master_o | output | 4 | Number of the master that owns the address phase |
| mastlock_o | output | 1 | Current address phase belongs to a locked sequence |

## Verification
The hardest case to reach is a grant handover in the middle of a fixed-length burst while BUSY beats and wait states stall the beat count. At the same time a higher-priority master is requesting and the owner has already dropped its request. Random stimulus seldom keeps a burst coherent that long. A directed sequence therefore runs a four-beat burst with an inserted BUSY beat and a wait cycle, and checks the exact edge at which the grant moves. Further directed steps cover the lock hold, the undefined-length hold, and a split mask followed by its release. A long random phase with sparse splits and releases is then compared cycle by cycle against a bench-side model.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int IDX_W = 4;
    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'b000,
        BT_INCR   = 3'b001,
        BT_WRAP4  = 3'b010,
        BT_INCR4  = 3'b011,
        BT_WRAP8  = 3'b100,
        BT_INCR8  = 3'b101,
        BT_WRAP16 = 3'b110,
        BT_INCR16 = 3'b111
    } burst_e;

    typedef struct packed {
        logic lock_hold;
        logic burst_hold;
        logic incr_hold;
    } hold_t;

    // number of beats implied by a burst type; 0 means open-ended
    function automatic logic [CNT_W-1:0] burst_beats(input logic [2:0] bt);
        logic [CNT_W-1:0] n;
        case (bt)
            BT_SINGLE:          n = CNT_W'(1);
            BT_INCR:            n = '0;
            BT_WRAP4, BT_INCR4: n = CNT_W'(4);
            BT_WRAP8, BT_INCR8: n = CNT_W'(8);
            default:            n = CNT_W'(16);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/arb_burst_track.sv
module arb_burst_track
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ready_i,
    input  logic [1:0] trans_i,
    input  logic [2:0] burst_i,
    input  logic       split_ev_i,
    output logic       burst_hold_o,
    output logic       incr_run_o
);
    logic [CNT_W-1:0] left_q, left_d;
    logic             incr_q, incr_d;
    logic [CNT_W-1:0] beats;

    assign beats = burst_beats(burst_i);

    always_comb begin
        left_d = left_q;
        incr_d = incr_q;
        if (ready_i) begin
            if (split_ev_i) begin
                left_d = '0;
                incr_d = 1'b0;
            end else begin
                case (trans_e'(trans_i))
                    TR_NSEQ: begin
                        left_d = (beats == '0) ? '0 : beats - CNT_W'(1);
                        incr_d = (burst_i == BT_INCR);
                    end
                    TR_SEQ: begin
                        if (left_q != '0) left_d = left_q - CNT_W'(1);
                    end
                    TR_IDLE: begin
                        left_d = '0;
                        incr_d = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            incr_q <= 1'b0;
        end else begin
            left_q <= left_d;
            incr_q <= incr_d;
        end
    end

    // two or more beats still to come after this edge
    assign burst_hold_o = (left_d >= CNT_W'(2));
    assign incr_run_o   = incr_d;

    // BUSY beats and wait cycles leave the beat count untouched
    p_busy_no_count_r4: assert property (@(posedge clk) disable iff (rst)
        (!split_ev_i && (!ready_i || trans_i == TR_BUSY)) |=> $stable(left_q));

    p_count_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        left_q <= CNT_W'(15));

endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask
    import arb_pkg::*;
#(
    parameter int NUM_M = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             split_ev_i,
    input  logic [IDX_W-1:0] victim_i,
    input  logic [NUM_M-1:0] release_i,
    output logic [NUM_M-1:0] mask_d_o
);
    logic [NUM_M-1:0] mask_q;
    logic [NUM_M-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (split_ev_i) set_vec[victim_i] = 1'b1;
    end

    assign mask_d_o = (mask_q & ~release_i) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d_o;
    end

    p_split_sets_r8: assert property (@(posedge clk) disable iff (rst)
        split_ev_i |=> mask_q[$past(victim_i)]);

    p_release_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (!split_ev_i && release_i != '0) |=> ((mask_q & $past(release_i)) == '0));

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import arb_pkg::*;
#(
    parameter int NUM_M     = 16,
    parameter int DEFAULT_M = 0
) (
    input  logic [NUM_M-1:0] elig_i,
    output logic [IDX_W-1:0] pick_o
);
    always_comb begin
        pick_o = IDX_W'(DEFAULT_M);
        for (int i = NUM_M - 1; i >= 0; i--) begin
            if (elig_i[i]) pick_o = IDX_W'(i);
        end
    end

    always_comb begin
        p_pick_valid_r2: assert (elig_i == '0 || elig_i[pick_o]);
    end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_M     = 16,
    parameter int DEFAULT_M = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_M-1:0] req_i,
    input  logic [NUM_M-1:0] lock_i,
    input  logic [1:0]       trans_i,
    input  logic [2:0]       burst_i,
    input  logic             ready_i,
    input  logic             split_resp_i,
    input  logic [NUM_M-1:0] split_done_i,
    output logic [NUM_M-1:0] grant_o,
    output logic [IDX_W-1:0] master_o,
    output logic             mastlock_o
);
    logic [IDX_W-1:0] gidx_q, gidx_d, owner_q, downer_q, pick;
    logic             mlock_q;
    logic             split_ev, incr_run, any_hold;
    logic [NUM_M-1:0] mask_d, elig;
    hold_t            hold;

    assign split_ev = ready_i && split_resp_i;

    arb_burst_track u_burst (
        .clk          (clk),
        .rst          (rst),
        .ready_i      (ready_i),
        .trans_i      (trans_i),
        .burst_i      (burst_i),
        .split_ev_i   (split_ev),
        .burst_hold_o (hold.burst_hold),
        .incr_run_o   (incr_run)
    );

    arb_split_mask #(.NUM_M(NUM_M)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .split_ev_i (split_ev),
        .victim_i   (downer_q),
        .release_i  (split_done_i),
        .mask_d_o   (mask_d)
    );

    assign elig = req_i & ~mask_d;

    arb_prio_pick #(.NUM_M(NUM_M), .DEFAULT_M(DEFAULT_M)) u_pick (
        .elig_i (elig),
        .pick_o (pick)
    );

    assign hold.lock_hold = mlock_q && lock_i[owner_q] && !split_ev;
    assign hold.incr_hold = incr_run && req_i[owner_q];
    assign any_hold       = |hold;
    assign gidx_d         = any_hold ? owner_q : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            gidx_q   <= IDX_W'(DEFAULT_M);
            owner_q  <= IDX_W'(DEFAULT_M);
            downer_q <= IDX_W'(DEFAULT_M);
            mlock_q  <= 1'b0;
        end else begin
            gidx_q <= gidx_d;
            if (ready_i) begin
                owner_q  <= gidx_q;
                downer_q <= owner_q;
                mlock_q  <= lock_i[gidx_q];
            end
        end
    end

    for (genvar g = 0; g < NUM_M; g++) begin : g_grant
        assign grant_o[g] = (gidx_q == IDX_W'(g));
    end

    assign master_o   = owner_q;
    assign mastlock_o = mlock_q;

    p_one_grant_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_o) == 1);

    p_owner_takes_r3: assert property (@(posedge clk) disable iff (rst)
        ready_i |=> master_o == $past(gidx_q));

    p_owner_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> $stable(master_o));

    p_lock_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        hold.lock_hold |=> grant_o[$past(owner_q)]);

    p_burst_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        hold.burst_hold |=> grant_o[$past(owner_q)]);

    p_default_park_r9: assert property (@(posedge clk) disable iff (rst)
        (elig == '0 && !any_hold) |=> grant_o[DEFAULT_M]);

endmodule

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
    localparam int N  = 16;
    localparam int DM = 0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0, lock = '0, sdone = '0;
    logic [1:0]    trans = 2'b00;
    logic [2:0]    burst = 3'b000;
    logic          ready = 1'b1, sresp = 1'b0;
    logic [N-1:0]  grant;
    logic [3:0]    master;
    logic          mlock;

    int n_chk = 0, n_fail = 0;

    // bench-side model state
    int            m_gidx, m_owner, m_downer, m_cnt;
    logic          m_lock, m_incr;
    logic [N-1:0]  m_mask;

    always #4 clk = ~clk;  // 125 MHz

    bus_arbiter #(.NUM_M(N), .DEFAULT_M(DM)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .lock_i(lock), .trans_i(trans),
        .burst_i(burst), .ready_i(ready), .split_resp_i(sresp),
        .split_done_i(sdone), .grant_o(grant), .master_o(master),
        .mastlock_o(mlock)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic int f_beats(input logic [2:0] b);
        if (b == 3'b000) return 1;
        if (b == 3'b001) return 0;
        if (b[2:1] == 2'b01) return 4;
        if (b[2:1] == 2'b10) return 8;
        return 16;
    endfunction

    function automatic int f_pick(input logic [N-1:0] e);
        for (int i = 0; i < N; i++) if (e[i]) return i;
        return DM;
    endfunction

    task automatic model_reset();
        m_gidx = DM; m_owner = DM; m_downer = DM; m_cnt = 0;
        m_lock = 1'b0; m_incr = 1'b0; m_mask = '0;
    endtask

    task automatic model_edge();
        logic         sev, hold;
        int           cnt_n;
        logic         incr_n;
        logic [N-1:0] mask_n, setv;
        sev = ready && sresp;
        cnt_n = m_cnt; incr_n = m_incr;
        if (ready) begin
            if (sev) begin cnt_n = 0; incr_n = 1'b0; end
            else if (trans == 2'b10) begin
                cnt_n = (f_beats(burst) == 0) ? 0 : f_beats(burst) - 1;
                incr_n = (burst == 3'b001);
            end else if (trans == 2'b11) begin
                if (m_cnt != 0) cnt_n = m_cnt - 1;
            end else if (trans == 2'b00) begin
                cnt_n = 0; incr_n = 1'b0;
            end
        end
        setv = '0;
        if (sev) setv[m_downer] = 1'b1;
        mask_n = (m_mask & ~sdone) | setv;
        hold = (m_lock && lock[m_owner] && !sev) || (cnt_n >= 2) ||
               (incr_n && req[m_owner]);
        if (ready) begin
            m_lock   = lock[m_gidx];
            m_downer = m_owner;
            m_owner  = m_gidx;
            if (hold) m_gidx = m_downer; // previous owner keeps the grant
            else      m_gidx = f_pick(req & ~mask_n);
        end else begin
            m_gidx = hold ? m_owner : f_pick(req & ~mask_n);
        end
        m_cnt = cnt_n; m_incr = incr_n; m_mask = mask_n;
    endtask

    // drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic step(input logic [N-1:0] rq, input logic [N-1:0] lk,
                        input logic [1:0] tr, input logic [2:0] bu,
                        input logic rdy, input logic sr, input logic [N-1:0] sd);
        req = rq; lock = lk; trans = tr; burst = bu; ready = rdy; sresp = sr; sdone = sd;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 grant vs model", grant, 32'(1) << m_gidx);
        chk("R3 owner vs model", master, m_owner);
        chk("R7 lock flag vs model", mlock, m_lock);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset grant", grant, 16'h0001);
        chk("R1 reset owner", master, 4'd0);
        chk("R1 reset lock flag", mlock, 1'b0);

        // R2/R3: master 2 requests alone
        step(16'h0004, '0, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R2 grant to lone requester", grant, 16'h0004);
        step(16'h0004, '0, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R3 owner after ready edge", master, 4'd2);
        // R4/R5: four-beat burst, owner drops request, master 1 waits
        step(16'h0002, '0, 2'b10, 3'b011, 1'b1, 1'b0, '0);
        chk("R4 hold after first beat", grant, 16'h0004);
        step(16'h0002, '0, 2'b11, 3'b011, 1'b1, 1'b0, '0);
        chk("R4 hold after second beat", grant, 16'h0004);
        step(16'h0002, '0, 2'b01, 3'b011, 1'b1, 1'b0, '0);
        chk("R4 BUSY does not count", grant, 16'h0004);
        step(16'h0002, '0, 2'b11, 3'b011, 1'b0, 1'b0, '0);
        chk("R4 wait does not count", grant, 16'h0004);
        chk("R3 owner stable in wait", master, 4'd2);
        step(16'h0002, '0, 2'b11, 3'b011, 1'b1, 1'b0, '0);
        chk("R5 grant moves at penultimate", grant, 16'h0002);
        chk("R5 owner unchanged at penultimate", master, 4'd2);
        step(16'h0002, '0, 2'b11, 3'b011, 1'b1, 1'b0, '0);
        chk("R5 owner after last beat", master, 4'd1);
        // R6: undefined-length burst
        step(16'h0003, '0, 2'b10, 3'b001, 1'b1, 1'b0, '0);
        chk("R6 hold while owner requests", grant, 16'h0002);
        step(16'h0001, '0, 2'b11, 3'b001, 1'b1, 1'b0, '0);
        chk("R6 rearbitrate on request drop", grant, 16'h0001);
        step(16'h0000, '0, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R9 park on default", grant, 16'h0001);
        // R7: locked sequence
        step(16'h0008, 16'h0008, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R7 grant to locking master", grant, 16'h0008);
        step(16'h0008, 16'h0008, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R7 lock flag set", mlock, 1'b1);
        chk("R7 owner is locking master", master, 4'd3);
        step(16'h0009, 16'h0008, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R7 lock holds against higher priority", grant, 16'h0008);
        step(16'h0001, 16'h0000, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R7 release on unlock", grant, 16'h0001);
        chk("R7 lock flag cleared", mlock, 1'b0);
        // R8: split mask and release
        step(16'h0008, '0, 2'b00, 3'b000, 1'b1, 1'b1, '0);
        chk("R8 split master masked", grant, 16'h0001);
        step(16'h0008, '0, 2'b00, 3'b000, 1'b1, 1'b0, '0);
        chk("R8 still masked", grant, 16'h0001);
        step(16'h0008, '0, 2'b00, 3'b000, 1'b1, 1'b0, 16'h0008);
        chk("R8 release restores eligibility", grant, 16'h0008);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] rq;
            rq = N'($urandom) & N'($urandom);
            step(rq, rq & N'($urandom) & N'($urandom), 2'($urandom), 3'($urandom),
                 ($urandom % 4) != 0, ($urandom % 25) == 0,
                 (($urandom % 6) == 0) ? N'($urandom) : '0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule